// File: doc/BRIEF.md
# Timer Interrupt Enable and Status Register

This block collects the expiry pulses of five timer channels into one 32-bit control word. Each channel owns an enable bit and a sticky status bit in that word, and the block drives one level interrupt line per channel. A channel's status bit is set by every expiry. Its interrupt line is raised only by an expiry that happens while the channel is enabled.

Software reaches the word through a single address on a small register port. A write does two things at once. It loads every enable bit directly from the written data. It clears each status bit whose matching data bit is one, and keeps the status bits whose data bit is zero. When a write clears a channel's status, that channel's interrupt line drops. Reads return the packed enables and status flags. Every other address reads as zero.

Top module: `timer_irq_ctrl`

## Requirements
- R1: After reset the enables, status flags and interrupt lines are all zero, and the word at byte address 0x44 reads as zero.
- R2: A write to address 0x44 loads enable bit i (data bit i, i = 0..4) from the written data, and the new value reads back in the next cycle.
- R3: A one-cycle expiry pulse on channel i sets status bit i (word bit 5+i) in the next cycle, whether or not the channel is enabled.
- R4: The interrupt line of channel i goes high in the cycle after an expiry on that channel, but only if enable bit i was set when the pulse arrived. An expiry on a disabled channel leaves its line low.
- R5: A write to 0x44 clears status bit i where data bit 5+i is one, and leaves it unchanged where that bit is zero.
- R6: The interrupt line of channel i goes low in the cycle after a write clears status bit i.
- R7: If an expiry and a clearing write for the same channel arrive in the same cycle, the status bit stays set and the interrupt line does not drop.
- R8: Setting an enable bit while that channel's status bit is already set does not raise the interrupt line.
- R9: Word bits 31 down to 10 always read as zero, and written values in those positions have no effect.
- R10: Writes to any address other than 0x44 change nothing, and reads from any other address return zero.
- R11: Clearing an enable bit does not lower an interrupt line that is already high. The line stays high until its status bit is cleared.
- R12: An expiry that arrives in the same cycle as a write that sets the enable is judged against the enable value held before that write, so it raises no interrupt.
- R13: An interrupt line is never high while its channel's status bit is clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Byte address used for both reads and writes |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| expire | input | 5 | One-cycle expiry pulse per channel |
| irq | output | 5 | Level interrupt line per channel |

## Verification
The assertions assume that each expiry is a single-cycle pulse from a counter that runs on the same clock. They also assume that the address and write strobe are stable around each clock edge, so that a write takes effect in exactly one cycle. The bench drives every input on the falling edge and holds each write or pulse for one cycle only. It then returns the inputs to idle, so every register update comes from one known edge. The collision and same-cycle-enable cases are produced on purpose by raising a pulse and a write in the same cycle. These are the only overlaps the stimulus creates.

// File: rtl/tirq_pkg.sv
package tirq_pkg;

    localparam int NUM_CH   = 5;
    localparam int DATA_W   = 32;
    localparam int EN_LSB   = 0;
    localparam int ST_LSB   = EN_LSB + NUM_CH;
    localparam int USED_W   = ST_LSB + NUM_CH;

    // Decoded write command for one clock cycle
    typedef struct packed {
        logic              hit;
        logic [NUM_CH-1:0] en_val;
        logic [NUM_CH-1:0] clr_mask;
    } wr_cmd_t;

    // Register state of one channel
    typedef struct packed {
        logic en;
        logic st;
        logic irq;
    } ch_state_t;

    function automatic logic [DATA_W-1:0] pack_word(
        input logic [NUM_CH-1:0] en,
        input logic [NUM_CH-1:0] st
    );
        logic [DATA_W-1:0] w;
        w = '0;
        w[EN_LSB +: NUM_CH] = en;
        w[ST_LSB +: NUM_CH] = st;
        return w;
    endfunction

endpackage

// File: rtl/tirq_decode.sv
module tirq_decode
    import tirq_pkg::*;
#(
    parameter int              ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h44
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output wr_cmd_t           cmd
);

    logic unused_hi;
    assign unused_hi = ^wdata[DATA_W-1:USED_W];

    always_comb begin
        cmd.hit      = wr_en && (addr == REG_OFFSET);
        cmd.en_val   = wdata[EN_LSB +: NUM_CH];
        cmd.clr_mask = cmd.hit ? wdata[ST_LSB +: NUM_CH] : '0;
    end

endmodule

// File: rtl/tirq_channel.sv
module tirq_channel
    import tirq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_hit,
    input  logic      wr_en_bit,
    input  logic      wr_clr,
    input  logic      expire,
    output ch_state_t state
);

    ch_state_t cur, nxt;

    always_comb begin
        nxt = cur;
        if (wr_hit)
            nxt.en = wr_en_bit;
        // expiry wins over a clearing write in the same cycle
        nxt.st = expire | (cur.st & ~wr_clr);
        if (expire && cur.en)
            nxt.irq = 1'b1;
        else if (wr_clr && !expire)
            nxt.irq = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cur <= '0;
        else
            cur <= nxt;
    end

    assign state = cur;

endmodule

// File: rtl/tirq_readback.sv
module tirq_readback
    import tirq_pkg::*;
#(
    parameter int              ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h44
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [NUM_CH-1:0] en,
    input  logic [NUM_CH-1:0] st,
    output logic [DATA_W-1:0] rd_data
);

    always_comb begin
        if (addr == REG_OFFSET)
            rd_data = pack_word(en, st);
        else
            rd_data = '0;
    end

endmodule

// File: rtl/timer_irq_ctrl.sv
module timer_irq_ctrl
    import tirq_pkg::*;
#(
    parameter int              ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h44
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_data,
    input  logic [NUM_CH-1:0] expire,
    output logic [NUM_CH-1:0] irq
);

    wr_cmd_t           cmd;
    logic [NUM_CH-1:0] en_q;
    logic [NUM_CH-1:0] st_q;

    tirq_decode #(
        .ADDR_W     (ADDR_W),
        .REG_OFFSET (REG_OFFSET)
    ) i_decode (
        .addr  (addr),
        .wr_en (wr_en),
        .wdata (wdata),
        .cmd   (cmd)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        ch_state_t s;
        tirq_channel i_channel (
            .clk       (clk),
            .rst       (rst),
            .wr_hit    (cmd.hit),
            .wr_en_bit (cmd.en_val[g]),
            .wr_clr    (cmd.clr_mask[g]),
            .expire    (expire[g]),
            .state     (s)
        );
        assign en_q[g] = s.en;
        assign st_q[g] = s.st;
        assign irq[g]  = s.irq;
    end

    tirq_readback #(
        .ADDR_W     (ADDR_W),
        .REG_OFFSET (REG_OFFSET)
    ) i_readback (
        .addr    (addr),
        .en      (en_q),
        .st      (st_q),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/timer_irq_ctrl_chk.sv
module timer_irq_ctrl_chk
    import tirq_pkg::*;
#(
    parameter int              ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h44
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rd_data,
    input logic [NUM_CH-1:0] expire,
    input logic [NUM_CH-1:0] irq,
    input logic [NUM_CH-1:0] en_q,
    input logic [NUM_CH-1:0] st_q
);

    logic wr_hit;
    assign wr_hit = wr_en && (addr == REG_OFFSET);

    // R9
    upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rd_data[DATA_W-1:USED_W] == '0);

    // R10
    foreign_write_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_hit |=> $stable(en_q));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_c
        // R3
        status_set_chk: assert property (@(posedge clk) disable iff (rst)
            expire[g] |=> st_q[g]);

        // R4
        irq_raise_chk: assert property (@(posedge clk) disable iff (rst)
            (expire[g] && en_q[g]) |=> irq[g]);

        // R8
        irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(irq[g]) |-> $past(expire[g] && en_q[g]));

        // R6
        irq_drop_chk: assert property (@(posedge clk) disable iff (rst)
            $fell(irq[g]) |-> $past(wr_hit && wdata[ST_LSB+g] && !expire[g]));

        // R13
        irq_needs_status_chk: assert property (@(posedge clk) disable iff (rst)
            irq[g] |-> st_q[g]);
    end

endmodule

bind timer_irq_ctrl timer_irq_ctrl_chk #(
    .ADDR_W     (ADDR_W),
    .REG_OFFSET (REG_OFFSET)
) i_timer_irq_ctrl_chk (
    .clk     (clk),
    .rst     (rst),
    .addr    (addr),
    .wr_en   (wr_en),
    .wdata   (wdata),
    .rd_data (rd_data),
    .expire  (expire),
    .irq     (irq),
    .en_q    (en_q),
    .st_q    (st_q)
);

// File: tb/test_timer_irq_ctrl.sv
module test_timer_irq_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] REG = 8'h44;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  addr = REG;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [4:0]  expire = '0;
    logic [31:0] rd_data;
    logic [4:0]  irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    timer_irq_ctrl i_timer_irq_ctrl (
        .clk     (clk),
        .rst     (rst),
        .addr    (addr),
        .wr_en   (wr_en),
        .wdata   (wdata),
        .rd_data (rd_data),
        .expire  (expire),
        .irq     (irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one active cycle, sampled after the edge, then back to idle
    task automatic step(input logic [7:0] a, input logic w, input logic [31:0] d,
                        input logic [4:0] ex);
        @(negedge clk);
        addr = a; wr_en = w; wdata = d; expire = ex;
        @(posedge clk);
        #(CLK_PERIOD/4);
        @(negedge clk);
        addr = REG; wr_en = 1'b0; wdata = '0; expire = '0;
        #1;
    endtask

    task automatic wr(input logic [31:0] d);
        step(REG, 1'b1, d, 5'b0);
    endtask

    task automatic pulse(input logic [4:0] ex);
        step(REG, 1'b0, 32'h0, ex);
    endtask

    task automatic clear_all();
        wr(32'h0000_03E0);
    endtask

    task automatic t_reset();
        chk("R1 word", rd_data, 32'h0);
        chk("R1 irq", {27'b0, irq}, 32'h0);
    endtask

    task automatic t_enable_rw();
        wr(32'h15);
        chk("R2 enables 15", rd_data, 32'h15);
        wr(32'h0A);
        chk("R2 enables 0A", rd_data, 32'h0A);
        clear_all();
    endtask

    task automatic t_status_any();
        pulse(5'b10001);
        chk("R3 status while disabled", rd_data, 32'h220);
        chk("R4 no irq while disabled", {27'b0, irq}, 32'h0);
        clear_all();
    endtask

    task automatic t_irq_gate();
        wr(32'h04);
        pulse(5'b00110);
        chk("R4 irq only enabled ch", {27'b0, irq}, 32'h04);
        chk("R3 status both", rd_data, 32'hC4);
    endtask

    task automatic t_w1c();
        wr(32'h44);
        chk("R5 clear ch1 keep ch2", rd_data, 32'h84);
        chk("R5 irq ch2 kept", {27'b0, irq}, 32'h04);
        wr(32'h00);
        chk("R11 irq after disable", {27'b0, irq}, 32'h04);
        chk("R11 word after disable", rd_data, 32'h80);
        wr(32'h80);
        chk("R6 irq dropped", {27'b0, irq}, 32'h0);
        chk("R5 status cleared", rd_data, 32'h0);
    endtask

    task automatic t_collision();
        clear_all();
        wr(32'h01);
        pulse(5'b00001);
        chk("R4 ch0 irq", {27'b0, irq}, 32'h01);
        step(REG, 1'b1, 32'h21, 5'b00001);
        chk("R7 status kept", rd_data, 32'h21);
        chk("R7 irq kept", {27'b0, irq}, 32'h01);
        step(REG, 1'b1, 32'h101, 5'b01000);
        chk("R7 disabled ch status kept", rd_data, 32'h121);
        clear_all();
    endtask

    task automatic t_late_enable();
        pulse(5'b00100);
        wr(32'h04);
        chk("R8 no irq on late enable", {27'b0, irq}, 32'h0);
        chk("R8 word", rd_data, 32'h84);
        pulse(5'b00100);
        chk("R4 later expiry raises", {27'b0, irq}, 32'h04);
        clear_all();
        step(REG, 1'b1, 32'h10, 5'b10000);
        chk("R12 old enable used", {27'b0, irq}, 32'h0);
        chk("R12 word", rd_data, 32'h210);
        clear_all();
    endtask

    task automatic t_upper_bits();
        wr(32'hFFFF_FC00);
        chk("R9 upper ignored", rd_data, 32'h0);
        wr(32'hFFFF_FFFF);
        chk("R9 upper read zero", rd_data, 32'h1F);
        clear_all();
    endtask

    task automatic t_other_addr();
        wr(32'h03);
        pulse(5'b00001);
        step(8'h40, 1'b1, 32'h3FC, 5'b0);
        chk("R10 foreign write ignored", rd_data, 32'h23);
        chk("R10 irq kept", {27'b0, irq}, 32'h01);
        @(negedge clk);
        addr = 8'h48;
        #1;
        chk("R10 foreign read zero", rd_data, 32'h0);
        addr = REG;
        clear_all();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_enable_rw();
        t_status_any();
        t_irq_gate();
        t_w1c();
        t_collision();
        t_late_enable();
        t_upper_bits();
        t_other_addr();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule